// File: doc/BRIEF.md
# Virtual Plane Routing Lookup

This block sits in a switch port that serves several root complexes over one shared fabric. Every packet header that reaches it carries a virtual plane number, a requester ID, a direction (toward the root complexes or toward the endpoints) and a target address. A management-loaded route table decides the outbound port. Each entry names a plane and a direction and gives an inclusive address window. An entry can also require one particular requester ID. It then supplies the egress port. A header is forwarded only when every field the entry asks for agrees. When nothing agrees, the header leaves flagged as an unsupported request and is steered to no port.

Ports that face legacy components, which do not understand planes, are bound through a second small table to exactly one plane each. A header arriving from such a port has its plane number replaced by the bound plane before the lookup. A header leaving toward such a port has its plane tag removed. Plane 0 is kept for in-band management: its traffic always goes to a fixed management port and the route table is not consulted. The lookup costs one register stage, with valid/ready flow control on both sides.

Top module: `plane_route_unit`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, every route entry is unused and every port is non-legacy, so a header on a nonzero plane comes out as an unsupported request.
- R2: A used entry hits only when its plane equals the header plane and `lo <= addr <= hi` (both bounds inclusive). On a hit `out_port_oh` has exactly one bit set, at bit position equal to the entry's egress port, and `out_ur` is 0.
- R3: When an entry's ID-check bit is set, the header's requester ID must also equal the entry's requester ID. When the bit is clear, the requester ID is ignored.
- R4: When several entries hit, the one with the lowest index decides the port. An entry written with its used bit at 0 never hits.
- R5: When no entry hits on a nonzero plane, `out_ur` is 1 and `out_port_oh` is all zeros.
- R6: A header whose source port (`in_src`) is bound as legacy takes that port's bound plane in place of `in_plane`. The lookup uses the bound plane, and `out_plane` shows it with `out_tagged` = 1.
- R7: When the chosen egress port is bound as legacy, the plane tag is stripped: `out_tagged` = 0 and `out_plane` = 0.
- R8: A header whose effective plane is 0 goes to port `MGMT_PORT` (one-hot), with `out_ur` = 0 and no table lookup.
- R9: A header accepted at a clock edge (`in_valid && in_ready`) appears on the outputs right after that edge. While `out_valid && !out_ready`, the outputs hold steady and `in_ready` is 0.
- R10: The direction bit (`in_up`: 1 = toward root complexes, 0 = toward endpoints) must equal the entry's direction bit, so each plane keeps separate upstream and downstream windows.
- R11: Configuration: `cfg_kind` = 0 writes route entry `cfg_idx` from the `cfg_*` fields. `cfg_kind` = 1 binds port `cfg_port` as legacy (`cfg_used` = 1) or non-legacy (`cfg_used` = 0) to plane `cfg_plane`. A write takes effect for headers accepted from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 = route entry, 1 = port binding |
| cfg_idx | input | $clog2(NUM_ENTRIES) | Route entry index |
| cfg_used | input | 1 | Entry used / port is legacy |
| cfg_id_chk | input | 1 | Entry requires requester ID match |
| cfg_rid | input | 16 | Entry requester ID |
| cfg_lo | input | 32 | Entry window low bound |
| cfg_hi | input | 32 | Entry window high bound |
| cfg_port | input | 3 | Entry egress port, or port being bound |
| cfg_plane | input | 4 | Entry plane, or bound plane |
| cfg_up | input | 1 | Entry direction, 1 = toward root complexes |
| in_valid | input | 1 | Header valid |
| in_ready | output | 1 | Header accepted this cycle when valid |
| in_src | input | 3 | Ingress port of the header |
| in_up | input | 1 | Header direction |
| in_plane | input | 4 | Header plane number |
| in_rid | input | 16 | Header requester ID |
| in_addr | input | 32 | Header address |
| out_valid | output | 1 | Routed header valid |
| out_ready | input | 1 | Downstream accepts routed header |
| out_port_oh | output | 8 | One-hot egress port, zero on unsupported request |
| out_ur | output | 1 | Unsupported request |
| out_tagged | output | 1 | Plane tag present |
| out_plane | output | 4 | Outgoing plane number |
| out_rid | output | 16 | Requester ID passed through |
| out_addr | output | 32 | Address passed through |
| out_up | output | 1 | Direction passed through |

## Verification
The hardest case to set up from the ports is the overlap of priority and qualification. A lower-index entry restricted to one requester ID and a higher-index open entry cover the same window. The decision must flip between them on the requester ID alone, and must fall back to the higher entry once the lower one is written unused. The stimulus builds this layering one configuration write at a time and sends the same address before and after each write. A second hard case chains ingress substitution and egress stripping. A header arrives from a legacy port with an unrelated plane number. It can only reach its entry through the substituted plane, and it then leaves through another legacy port, so both bindings act on the same header. Backpressure is produced by holding `out_ready` low while a second header waits at the input.

// File: rtl/plane_route_pkg.sv
package plane_route_pkg;

    localparam int PLANE_W   = 4;
    localparam int ADDR_W    = 32;
    localparam int RID_W     = 16;
    localparam int NUM_PORTS = 8;
    localparam int PORT_W    = $clog2(NUM_PORTS);

    typedef logic [PLANE_W-1:0] plane_t;
    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [RID_W-1:0]   rid_t;
    typedef logic [PORT_W-1:0]  port_t;

    // One route table entry
    typedef struct packed {
        logic   used;
        logic   id_chk;
        rid_t   rid;
        addr_t  lo;
        addr_t  hi;
        port_t  egress;
        plane_t plane;
        logic   upstream;
    } route_ent_t;

    // Lookup key after plane substitution
    typedef struct packed {
        port_t  src;
        logic   upstream;
        plane_t plane;
        rid_t   rid;
        addr_t  addr;
    } hdr_t;

    function automatic logic ent_hits(route_ent_t e, hdr_t h);
        return e.used
            && (e.plane == h.plane)
            && (e.upstream == h.upstream)
            && (h.addr >= e.lo)
            && (h.addr <= e.hi)
            && (!e.id_chk || (e.rid == h.rid));
    endfunction

    function automatic logic [NUM_PORTS-1:0] port_onehot(port_t p);
        return NUM_PORTS'(1) << p;
    endfunction

endpackage

// File: rtl/pr_route_table.sv
module pr_route_table
    import plane_route_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IW = $clog2(NUM_ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IW-1:0]           wr_idx,
    input  route_ent_t              wr_ent,
    input  hdr_t                    key,
    output logic [NUM_ENTRIES-1:0]  hit_vec,
    output port_t [NUM_ENTRIES-1:0] egress_tab
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        route_ent_t ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                ent_q <= wr_ent;
            end
        end

        assign hit_vec[g]    = ent_hits(ent_q, key);
        assign egress_tab[g] = ent_q.egress;
    end

endmodule

// File: rtl/pr_first_hit.sv
module pr_first_hit #(
    parameter int NUM_ENTRIES = 8,
    localparam int IW = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] hit_vec,
    output logic                   any_hit,
    output logic [IW-1:0]          win_idx
);

    always_comb begin
        any_hit = |hit_vec;
        win_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                win_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/pr_port_bind.sv
module pr_port_bind
    import plane_route_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  port_t  wr_port,
    input  logic   wr_legacy,
    input  plane_t wr_plane,
    input  port_t  ing_port,
    output logic   ing_legacy,
    output plane_t ing_plane,
    input  port_t  egr_port,
    output logic   egr_legacy
);

    logic   [NUM_PORTS-1:0] legacy_q;
    plane_t [NUM_PORTS-1:0] plane_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                legacy_q[p] <= 1'b0;
                plane_q[p]  <= '0;
            end else if (wr_en && (wr_port == PORT_W'(p))) begin
                legacy_q[p] <= wr_legacy;
                plane_q[p]  <= wr_plane;
            end
        end
    end

    assign ing_legacy = legacy_q[ing_port];
    assign ing_plane  = plane_q[ing_port];
    assign egr_legacy = legacy_q[egr_port];

endmodule

// File: rtl/plane_route_unit.sv
module plane_route_unit
    import plane_route_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int MGMT_PORT   = 7,
    localparam int IW = $clog2(NUM_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic                 cfg_kind,
    input  logic [IW-1:0]        cfg_idx,
    input  logic                 cfg_used,
    input  logic                 cfg_id_chk,
    input  logic [RID_W-1:0]     cfg_rid,
    input  logic [ADDR_W-1:0]    cfg_lo,
    input  logic [ADDR_W-1:0]    cfg_hi,
    input  logic [PORT_W-1:0]    cfg_port,
    input  logic [PLANE_W-1:0]   cfg_plane,
    input  logic                 cfg_up,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [PORT_W-1:0]    in_src,
    input  logic                 in_up,
    input  logic [PLANE_W-1:0]   in_plane,
    input  logic [RID_W-1:0]     in_rid,
    input  logic [ADDR_W-1:0]    in_addr,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [NUM_PORTS-1:0] out_port_oh,
    output logic                 out_ur,
    output logic                 out_tagged,
    output logic [PLANE_W-1:0]   out_plane,
    output logic [RID_W-1:0]     out_rid,
    output logic [ADDR_W-1:0]    out_addr,
    output logic                 out_up
);

    route_ent_t               wr_ent;
    hdr_t                     key;
    logic [NUM_ENTRIES-1:0]   hit_vec;
    port_t [NUM_ENTRIES-1:0]  egress_tab;
    logic                     any_hit;
    logic [IW-1:0]            win_idx;
    logic                     src_legacy;
    plane_t                   src_plane;
    logic                     dst_legacy;
    logic                     is_mgmt;
    logic                     miss;
    logic                     strip;
    port_t                    dst;

    always_comb begin
        wr_ent.used     = cfg_used;
        wr_ent.id_chk   = cfg_id_chk;
        wr_ent.rid      = cfg_rid;
        wr_ent.lo       = cfg_lo;
        wr_ent.hi       = cfg_hi;
        wr_ent.egress   = cfg_port;
        wr_ent.plane    = cfg_plane;
        wr_ent.upstream = cfg_up;
    end

    // Plane substitution for legacy ingress happens before the lookup
    always_comb begin
        key.src      = in_src;
        key.upstream = in_up;
        key.rid      = in_rid;
        key.addr     = in_addr;
        key.plane    = src_legacy ? src_plane : in_plane;
    end

    pr_route_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_we && !cfg_kind),
        .wr_idx     (cfg_idx),
        .wr_ent     (wr_ent),
        .key        (key),
        .hit_vec    (hit_vec),
        .egress_tab (egress_tab)
    );

    pr_first_hit #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
        .hit_vec (hit_vec),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    pr_port_bind u_bind (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cfg_we && cfg_kind),
        .wr_port    (cfg_port),
        .wr_legacy  (cfg_used),
        .wr_plane   (cfg_plane),
        .ing_port   (in_src),
        .ing_legacy (src_legacy),
        .ing_plane  (src_plane),
        .egr_port   (dst),
        .egr_legacy (dst_legacy)
    );

    always_comb begin
        is_mgmt = (key.plane == '0);
        dst     = is_mgmt ? PORT_W'(MGMT_PORT) : egress_tab[win_idx];
        miss    = !is_mgmt && !any_hit;
        strip   = !miss && dst_legacy;
    end

    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_port_oh <= '0;
            out_ur      <= 1'b0;
            out_tagged  <= 1'b0;
            out_plane   <= '0;
            out_rid     <= '0;
            out_addr    <= '0;
            out_up      <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_port_oh <= miss ? '0 : port_onehot(dst);
                out_ur      <= miss;
                out_tagged  <= !strip;
                out_plane   <= strip ? '0 : key.plane;
                out_rid     <= in_rid;
                out_addr    <= in_addr;
                out_up      <= in_up;
            end
        end
    end

    AST_PICK_IS_HIT: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> hit_vec[win_idx]) else $error("picked entry not a hit"); // R4
    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> ((hit_vec & ((NUM_ENTRIES'(1) << win_idx) - NUM_ENTRIES'(1))) == '0))
        else $error("lower hit skipped"); // R4
    AST_UR_NO_PORT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ur) |-> (out_port_oh == '0)) else $error("UR with port"); // R5
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ur) |-> ($countones(out_port_oh) == 1)) else $error("port not one-hot"); // R2
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_port_oh) && $stable(out_addr)
                                       && $stable(out_plane))) else $error("output moved in stall"); // R9
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready) else $error("ready during stall"); // R9
    AST_STRIP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_tagged) |-> (out_plane == '0)) else $error("stripped plane nonzero"); // R7
    AST_MGMT_PORT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_tagged && out_plane == '0) |-> (out_port_oh == port_onehot(PORT_W'(MGMT_PORT))))
        else $error("plane 0 not to mgmt"); // R8

endmodule

// File: tb/plane_route_unit_bench.sv
module plane_route_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we, cfg_kind, cfg_used, cfg_id_chk, cfg_up;
    logic [2:0]  cfg_idx;
    logic [15:0] cfg_rid;
    logic [31:0] cfg_lo, cfg_hi;
    logic [2:0]  cfg_port;
    logic [3:0]  cfg_plane;
    logic        in_valid, in_ready, in_up;
    logic [2:0]  in_src;
    logic [3:0]  in_plane;
    logic [15:0] in_rid;
    logic [31:0] in_addr;
    logic        out_valid, out_ready, out_ur, out_tagged, out_up;
    logic [7:0]  out_port_oh;
    logic [3:0]  out_plane;
    logic [15:0] out_rid;
    logic [31:0] out_addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    plane_route_unit u_plane_route_unit (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_used(cfg_used),
        .cfg_id_chk(cfg_id_chk), .cfg_rid(cfg_rid), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .cfg_port(cfg_port), .cfg_plane(cfg_plane), .cfg_up(cfg_up),
        .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src), .in_up(in_up),
        .in_plane(in_plane), .in_rid(in_rid), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_port_oh(out_port_oh),
        .out_ur(out_ur), .out_tagged(out_tagged), .out_plane(out_plane),
        .out_rid(out_rid), .out_addr(out_addr), .out_up(out_up)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic write_route(logic [2:0] idx, logic used, logic idc, logic [15:0] rid,
                               logic [31:0] lo, logic [31:0] hi, logic [2:0] port,
                               logic [3:0] plane, logic up);
        @(negedge clk);
        cfg_we = 1; cfg_kind = 0; cfg_idx = idx; cfg_used = used; cfg_id_chk = idc;
        cfg_rid = rid; cfg_lo = lo; cfg_hi = hi; cfg_port = port; cfg_plane = plane; cfg_up = up;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic bind_port(logic [2:0] port, logic legacy, logic [3:0] plane);
        @(negedge clk);
        cfg_we = 1; cfg_kind = 1; cfg_port = port; cfg_used = legacy; cfg_plane = plane;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Send one header with out_ready high and check the routed result
    task automatic route_chk(string req, logic [2:0] src, logic up, logic [3:0] plane,
                             logic [15:0] rid, logic [31:0] addr,
                             logic [7:0] e_oh, logic e_ur, logic e_tag, logic [3:0] e_plane);
        @(negedge clk);
        in_valid = 1; in_src = src; in_up = up; in_plane = plane; in_rid = rid; in_addr = addr;
        @(negedge clk);
        in_valid = 0;
        chk(req, "out_valid", 32'(out_valid), 32'h1);
        chk(req, "port_oh", 32'(out_port_oh), 32'(e_oh));
        chk(req, "ur", 32'(out_ur), 32'(e_ur));
        chk(req, "tagged", 32'(out_tagged), 32'(e_tag));
        chk(req, "plane", 32'(out_plane), 32'(e_plane));
        chk(req, "addr", out_addr, addr);
        chk(req, "rid", 32'(out_rid), 32'(rid));
    endtask

    task automatic t_reset();
        chk("R1", "out_valid after reset", 32'(out_valid), 32'h0);
        chk("R1", "in_ready after reset", 32'(in_ready), 32'h1);
        route_chk("R1", 3'd0, 1'b0, 4'd2, 16'h0, 32'h1000, 8'h00, 1'b1, 1'b1, 4'd2);
    endtask

    task automatic t_window();
        write_route(3'd0, 1, 0, 16'h0, 32'h1000, 32'h1FFF, 3'd3, 4'd2, 1'b0);
        route_chk("R2", 3'd0, 1'b0, 4'd2, 16'h0, 32'h1000, 8'h08, 1'b0, 1'b1, 4'd2);
        route_chk("R2", 3'd0, 1'b0, 4'd2, 16'h0, 32'h1FFF, 8'h08, 1'b0, 1'b1, 4'd2);
        route_chk("R5", 3'd0, 1'b0, 4'd2, 16'h0, 32'h0FFF, 8'h00, 1'b1, 1'b1, 4'd2);
        route_chk("R5", 3'd0, 1'b0, 4'd2, 16'h0, 32'h2000, 8'h00, 1'b1, 1'b1, 4'd2);
        route_chk("R2", 3'd0, 1'b0, 4'd3, 16'h0, 32'h1000, 8'h00, 1'b1, 1'b1, 4'd3);
        route_chk("R10", 3'd0, 1'b1, 4'd2, 16'h0, 32'h1000, 8'h00, 1'b1, 1'b1, 4'd2);
    endtask

    task automatic t_rid_prio();
        write_route(3'd1, 1, 1, 16'h0108, 32'h3000, 32'h3FFF, 3'd5, 4'd2, 1'b0);
        route_chk("R3", 3'd0, 1'b0, 4'd2, 16'h0108, 32'h3000, 8'h20, 1'b0, 1'b1, 4'd2);
        route_chk("R3", 3'd0, 1'b0, 4'd2, 16'h0109, 32'h3000, 8'h00, 1'b1, 1'b1, 4'd2);
        write_route(3'd2, 1, 0, 16'h0, 32'h3000, 32'h3FFF, 3'd6, 4'd2, 1'b0);
        route_chk("R3", 3'd0, 1'b0, 4'd2, 16'h0109, 32'h3800, 8'h40, 1'b0, 1'b1, 4'd2);
        route_chk("R4", 3'd0, 1'b0, 4'd2, 16'h0108, 32'h3800, 8'h20, 1'b0, 1'b1, 4'd2);
    endtask

    task automatic t_overlap();
        write_route(3'd4, 1, 0, 16'h0, 32'h8000, 32'h8FFF, 3'd1, 4'd1, 1'b1);
        write_route(3'd3, 1, 0, 16'h0, 32'h8000, 32'h8FFF, 3'd2, 4'd1, 1'b1);
        route_chk("R4", 3'd0, 1'b1, 4'd1, 16'h0, 32'h8800, 8'h04, 1'b0, 1'b1, 4'd1);
        write_route(3'd3, 0, 0, 16'h0, 32'h8000, 32'h8FFF, 3'd2, 4'd1, 1'b1);
        route_chk("R11", 3'd0, 1'b1, 4'd1, 16'h0, 32'h8800, 8'h02, 1'b0, 1'b1, 4'd1);
    endtask

    task automatic t_legacy();
        bind_port(3'd4, 1'b1, 4'd1);
        route_chk("R6", 3'd4, 1'b1, 4'd9, 16'h0, 32'h8800, 8'h02, 1'b0, 1'b1, 4'd1);
        route_chk("R6", 3'd0, 1'b1, 4'd9, 16'h0, 32'h8800, 8'h00, 1'b1, 1'b1, 4'd9);
        bind_port(3'd1, 1'b1, 4'd5);
        route_chk("R7", 3'd4, 1'b1, 4'd9, 16'h0, 32'h8800, 8'h02, 1'b0, 1'b0, 4'd0);
    endtask

    task automatic t_mgmt();
        route_chk("R8", 3'd0, 1'b0, 4'd0, 16'h0, 32'h1000, 8'h80, 1'b0, 1'b1, 4'd0);
    endtask

    task automatic t_stall();
        @(negedge clk);
        out_ready = 0;
        in_valid = 1; in_src = 0; in_up = 0; in_plane = 2; in_rid = 16'h0; in_addr = 32'h1000;
        @(negedge clk);
        chk("R9", "A out_valid", 32'(out_valid), 32'h1);
        in_rid = 16'h0109; in_addr = 32'h3000;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9", "A held addr", out_addr, 32'h1000);
            chk("R9", "in_ready in stall", 32'(in_ready), 32'h0);
        end
        out_ready = 1;
        @(negedge clk);
        in_valid = 0;
        chk("R9", "B addr", out_addr, 32'h3000);
        chk("R9", "B port", 32'(out_port_oh), 32'h40);
        @(negedge clk);
        chk("R9", "drained", 32'(out_valid), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        report();
    end

    initial begin
        rst = 1; cfg_we = 0; cfg_kind = 0; cfg_idx = 0; cfg_used = 0; cfg_id_chk = 0;
        cfg_rid = 0; cfg_lo = 0; cfg_hi = 0; cfg_port = 0; cfg_plane = 0; cfg_up = 0;
        in_valid = 0; in_src = 0; in_up = 0; in_plane = 0; in_rid = 0; in_addr = 0;
        out_ready = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_window();
        t_rid_prio();
        t_overlap();
        t_legacy();
        t_mgmt();
        t_stall();
        report();
    end

endmodule